// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between a byte-oriented fetch buffer and the execute stage of an 8-bit controller core. Each cycle the fetch buffer offers up to four instruction bytes on four lanes, with a count of how many of them are valid. Lane 0 always holds the first byte of an instruction. The block classifies that byte, and where needed the second one, and reports four results: the instruction length in bytes, a class index, an operand-mode code, and an invalid flag. The fetch unit uses the length to advance its program counter.

The first byte is split on bit 3. When bit 3 is clear, the low nibble selects a family and the high nibble selects a row within it. When bit 3 is set, bits 7:5 select the group. Two opcodes, 0x40 and 0x98, can only be classified once the second byte has been examined.

If the fetch buffer holds fewer bytes than the instruction needs, the block raises a stall and accepts nothing. It never reports a partial decode. Results are registered and leave through a valid/ready pair. An unrecognised encoding is reported with a length of 1 so that the fetch unit can step past it.

Top module: `insn_predecode`

## Requirements
- R1: Byte lane k of `in_bytes` is bits [8k+7:8k]. `in_ready` equals `!out_valid || out_ready`. When `in_valid`, `in_ready` and `in_count` ≥ the base length are all true, the decode is captured. It appears on the next rising edge with `out_valid` high. In any other case, a rising edge where `in_ready` is high clears `out_valid`.
- R2: The base length is the number of bytes needed to decode. It is 2 for opcodes 0x40 and 0x98, and it equals the decoded length for every other opcode. `need_more` is high whenever `in_valid` is high and `in_count` is below the base length. In that case nothing is captured.
- R3: While `out_valid` is high and `out_ready` is low, every output field keeps its value and no new input is taken.
- R4: Low nibble 0 (bit 3 clear): the class is the high nibble (0x00–0x0F). 0x20 and 0x30 are length 3, mode 10 (17-bit absolute). 0x50 is invalid. All other rows except 0x40 are length 1, mode 0.
- R5: For 0x40, the selector byte must have bits 5:0 equal to zero. Bits 7:6 of that byte then give class 0x60+sel, with length 2 and mode 15. Any other selector value is invalid.
- R6: Low nibble 1 gives class 0x10+high nibble, with these forms:
  - 0x01 and 0x11: length 3, mode 9 (immediate then relative).
  - 0x21 and 0x31: length 3, mode 10.
  - 0x41 and 0x51: length 2, mode 8 (relative byte).
  - 0x71 and 0x91: length 2, mode 1 (indirect byte).
  - All others: length 2, mode 6 (8-bit immediate).
- R7: Low nibbles 2–6 give class 0x20+high nibble. The opcode bits 2:0 select the mode: 2→1, 3→2, 4→3, 5→4, 6→5 (16-bit absolute). Length is 2, or 3 when bits 2:0 are 6. The 0x4_ row (move) adds one more byte.
- R8: Low nibble 7 gives class 0x30+high nibble, with these forms:
  - High nibble 0–3: length 2, mode 1.
  - High nibble 4: length 3, mode 7 (16-bit immediate).
  - High nibble 5–9: length 3, mode 5.
  - High nibble A–F: length 4, mode 13 (two bit-address bytes then relative).
- R9: Bit 3 set with bits 7:5 = g ≠ 4 gives class 0x40+g, with these forms:
  - g 0–1 (bit branch): length 3, mode 12.
  - g 2–3 (relative call or branch): length 2, mode 14.
  - g 5–7 (bit modify): length 2, mode 11.
- R10: Opcodes 0x88–0x8F and 0x98–0x9F give class 0x50 + 8·bit4 + form, where bits 2:0 select the form:
  - 0: load form, length 2, mode 1 (0x88 only; 0x98 is covered by R11).
  - 1: form 1 (zero branch), length 2, mode 8.
  - 2–5: form 2 (increment or decrement), length 2, mode as in R7.
  - 6: form 3 (long), length 3, mode 5.
  - 7: form 4 (word), length 2, mode 1.
- R11: For 0x98, the second byte must have its low nibble zero. Its high nibble h then gives class 0x70+h, with length 2 and mode 15. Any other second byte is invalid.
- R12: An invalid decode reports `out_invalid`=1 in the same output as length 1, class 0 and mode 0.
- R13: During and just after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch buffer offers bytes |
| in_bytes | input | 32 | Four byte lanes, lane 0 = first byte |
| in_count | input | 3 | Number of valid lanes (0–4) |
| in_ready | output | 1 | Block can capture a decode |
| need_more | output | 1 | Too few bytes for this instruction |
| out_valid | output | 1 | Registered decode available |
| out_ready | input | 1 | Consumer takes the decode |
| out_len | output | 3 | Instruction length, 1–4 |
| out_class | output | 7 | Class index |
| out_mode | output | 4 | Operand-mode code |
| out_invalid | output | 1 | Encoding not recognised |

## Verification
`need_more` and `in_ready` are combinational, so they are valid in the same cycle the bytes are presented. The bench reads them 1 ns after driving at a falling edge. Every decode field sits one register behind acceptance. The bench therefore samples `out_valid` and the fields at the falling edge that follows the capturing rising edge. During backpressure, the bench holds `out_ready` low across several edges while offering different bytes. It re-reads the outputs at each falling edge to confirm they have not moved.

// File: rtl/insn_predecode.sv
module insn_predecode #(
  parameter int LANES = 4,
  localparam int BW = 8 * LANES,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_bytes,
  input  logic [CW-1:0] in_count,
  output logic          in_ready,
  output logic          need_more,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_len,
  output logic [6:0]    out_class,
  output logic [3:0]    out_mode,
  output logic          out_invalid
);

  localparam logic [3:0] M_NONE = 4'd0, M_IND = 4'd1, M_ABS16 = 4'd5, M_IMM8 = 4'd6,
                         M_IMM16 = 4'd7, M_REL8 = 4'd8, M_IMMREL = 4'd9, M_ABS17 = 4'd10,
                         M_BIT = 4'd11, M_BITREL = 4'd12, M_BITWREL = 4'd13, M_REL11 = 4'd14,
                         M_SUB = 4'd15;

  wire [7:0] op = in_bytes[7:0];
  wire [7:0] b1 = in_bytes[15:8];
  wire [3:0] hi = op[7:4];
  wire [3:0] lo = op[3:0];
  wire [2:0] m3 = op[2:0];

  function automatic logic [3:0] field_mode(input logic [2:0] k);
    case (k)
      3'd2: field_mode = M_IND;
      3'd3: field_mode = 4'd2;
      3'd4: field_mode = 4'd3;
      3'd5: field_mode = 4'd4;
      3'd6: field_mode = M_ABS16;
      default: field_mode = M_NONE;
    endcase
  endfunction

  logic [2:0] blen;
  logic [6:0] cls;
  logic [3:0] mode;
  logic       bad;

  always_comb begin
    blen = 3'd1; cls = 7'd0; mode = M_NONE; bad = 1'b0;
    if (!op[3]) begin
      case (lo)
        4'd0: begin
          cls = {3'b000, hi};
          if (hi == 4'h2 || hi == 4'h3) begin
            blen = 3'd3; mode = M_ABS17;
          end else if (hi == 4'h4) begin
            blen = 3'd2; mode = M_SUB; cls = {5'b11000, b1[7:6]}; bad = |b1[5:0];
          end else if (hi == 4'h5) begin
            bad = 1'b1;
          end
        end
        4'd1: begin
          cls = {3'b001, hi};
          if (hi < 4'h2) begin
            blen = 3'd3; mode = M_IMMREL;
          end else if (hi < 4'h4) begin
            blen = 3'd3; mode = M_ABS17;
          end else if (hi < 4'h6) begin
            blen = 3'd2; mode = M_REL8;
          end else if (hi == 4'h7 || hi == 4'h9) begin
            blen = 3'd2; mode = M_IND;
          end else begin
            blen = 3'd2; mode = M_IMM8;
          end
        end
        4'd7: begin
          cls = {3'b011, hi};
          if (hi < 4'h4) begin
            blen = 3'd2; mode = M_IND;
          end else if (hi == 4'h4) begin
            blen = 3'd3; mode = M_IMM16;
          end else if (hi < 4'hA) begin
            blen = 3'd3; mode = M_ABS16;
          end else begin
            blen = 3'd4; mode = M_BITWREL;
          end
        end
        default: begin
          cls  = {3'b010, hi};
          mode = field_mode(m3);
          blen = (m3 == 3'd6) ? 3'd3 : 3'd2;
          if (hi == 4'h4) blen = blen + 3'd1;
        end
      endcase
    end else if (op[7:5] != 3'd4) begin
      cls = {4'b1000, op[7:5]};
      case (op[7:5])
        3'd0, 3'd1: begin blen = 3'd3; mode = M_BITREL; end
        3'd2, 3'd3: begin blen = 3'd2; mode = M_REL11; end
        default:    begin blen = 3'd2; mode = M_BIT; end
      endcase
    end else begin
      case (m3)
        3'd0: begin
          blen = 3'd2;
          if (op[4]) begin
            mode = M_SUB; cls = {3'b111, b1[7:4]}; bad = |b1[3:0];
          end else begin
            mode = M_IND; cls = 7'h50;
          end
        end
        3'd1:    begin blen = 3'd2; mode = M_REL8;  cls = {3'b101, op[4], 3'd1}; end
        3'd6:    begin blen = 3'd3; mode = M_ABS16; cls = {3'b101, op[4], 3'd3}; end
        3'd7:    begin blen = 3'd2; mode = M_IND;   cls = {3'b101, op[4], 3'd4}; end
        default: begin blen = 3'd2; mode = field_mode(m3); cls = {3'b101, op[4], 3'd2}; end
      endcase
    end
  end

  assign need_more = in_valid && ({{(3 > CW ? 3 - CW : 0){1'b0}}, in_count} < {{(CW > 3 ? CW - 3 : 0){1'b0}}, blen});
  assign in_ready  = !out_valid || out_ready;
  wire   take      = in_valid && in_ready && !need_more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_len <= 3'd0; out_class <= 7'd0; out_mode <= 4'd0; out_invalid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= take;
      if (take) begin
        out_invalid <= bad;
        out_len     <= bad ? 3'd1 : blen;
        out_class   <= bad ? 7'd0 : cls;
        out_mode    <= bad ? M_NONE : mode;
      end
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd4)); // R1
  AST_SHORT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (need_more && in_ready) |=> !out_valid); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_class) && $stable(out_mode))); // R3
  AST_BAD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_len == 3'd1 && out_class == 7'd0 && out_mode == 4'd0)); // R12
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R13

endmodule

// File: tb/tb_insn_predecode.sv
module tb_insn_predecode;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_bytes = '0;
  logic [2:0] in_count = '0;
  logic in_ready, need_more, out_valid, out_invalid;
  logic [2:0] out_len;
  logic [6:0] out_class;
  logic [3:0] out_mode;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  insn_predecode dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_count(in_count), .in_ready(in_ready), .need_more(need_more), .out_valid(out_valid),
    .out_ready(out_ready), .out_len(out_len), .out_class(out_class), .out_mode(out_mode),
    .out_invalid(out_invalid));

  // returns {inv, len[2:0], base[2:0], cls[6:0], mode[3:0]}
  function automatic logic [17:0] expect_of(input logic [7:0] o, input logic [7:0] s);
    logic [2:0] ln; logic [6:0] c; logic [3:0] m; logic iv; logic [2:0] base;
    ln = 1; c = 0; m = 0; iv = 0;
    if (o[3] == 1'b0 && o[3:0] == 4'h0) begin                 // R4 / R5
      c = {3'd0, o[7:4]};
      if (o == 8'h20 || o == 8'h30) begin ln = 3; m = 10; end
      if (o == 8'h50) iv = 1;
      if (o == 8'h40) begin ln = 2; m = 15; c = 7'h60 + {5'd0, s[7:6]}; iv = (s[5:0] != 0); end
    end else if (o[3:0] == 4'h1) begin                         // R6
      c = 7'h10 + {3'd0, o[7:4]};
      if (o == 8'h01 || o == 8'h11) begin ln = 3; m = 9; end
      else if (o == 8'h21 || o == 8'h31) begin ln = 3; m = 10; end
      else if (o == 8'h41 || o == 8'h51) begin ln = 2; m = 8; end
      else if (o == 8'h71 || o == 8'h91) begin ln = 2; m = 1; end
      else begin ln = 2; m = 6; end
    end else if (o[3:0] >= 4'h2 && o[3:0] <= 4'h6) begin       // R7
      c = 7'h20 + {3'd0, o[7:4]};
      m = (o[3:0] == 6) ? 4'd5 : {1'b0, o[2:0]} - 4'd1;
      ln = (o[3:0] == 6) ? 3'd3 : 3'd2;
      if (o[7:4] == 4) ln = ln + 1;
    end else if (o[3:0] == 4'h7) begin                         // R8
      c = 7'h30 + {3'd0, o[7:4]};
      if (o < 8'h40) begin ln = 2; m = 1; end
      else if (o == 8'h47) begin ln = 3; m = 7; end
      else if (o < 8'hA0) begin ln = 3; m = 5; end
      else begin ln = 4; m = 13; end
    end else if (o >= 8'h88 && o <= 8'h9F) begin               // R10 / R11
      c = (o >= 8'h98) ? 7'h58 : 7'h50;
      case (o[2:0])
        0: begin ln = 2; m = 1;
             if (o == 8'h98) begin m = 15; c = 7'h70 + {3'd0, s[7:4]}; iv = (s[3:0] != 0); end end
        1: begin ln = 2; m = 8; c = c + 1; end
        6: begin ln = 3; m = 5; c = c + 3; end
        7: begin ln = 2; m = 1; c = c + 4; end
        default: begin ln = 2; m = {1'b0, o[2:0]} - 4'd1; c = c + 2; end
      endcase
    end else begin                                             // R9
      c = 7'h40 + {4'd0, o[7:5]};
      if (o < 8'h40) begin ln = 3; m = 12; end
      else if (o < 8'h80) begin ln = 2; m = 14; end
      else begin ln = 2; m = 11; end
    end
    base = ln;
    if (iv) begin ln = 1; c = 0; m = 0; end
    return {iv, ln, base, c, m};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic trial(input logic [31:0] by, input logic [2:0] cnt, input string req);
    logic [17:0] e; logic nm;
    e = expect_of(by[7:0], by[15:8]);
    nm = (cnt < e[13:11]);
    @(negedge clk);
    in_bytes = by; in_count = cnt; in_valid = 1'b1;
    #1 chk(need_more == nm, "R2 need_more", int'(need_more), int'(nm));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == !nm, "R1 out_valid", int'(out_valid), int'(!nm));
    if (!nm) begin
      chk(out_len == e[16:14], {req, " len"}, int'(out_len), int'(e[16:14]));
      chk(out_class == e[10:4], {req, " class"}, int'(out_class), int'(e[10:4]));
      chk(out_mode == e[3:0], {req, " mode"}, int'(out_mode), int'(e[3:0]));
      chk(out_invalid == e[17], {req, " R12 invalid"}, int'(out_invalid), int'(e[17]));
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R13 reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R13 after reset", int'(out_valid), 0);

    trial(32'h0000_0050, 3'd4, "R12 0x50");
    trial(32'h0000_0020, 3'd3, "R4 abs17");
    trial(32'h0000_0020, 3'd2, "R2 short");
    trial(32'h0000_C040, 3'd2, "R5 sel3");
    trial(32'h0000_0140, 3'd2, "R5 bad sel");
    trial(32'h0000_0040, 3'd1, "R2 0x40 one byte");
    trial(32'h0000_5098, 3'd2, "R11 op5");
    trial(32'h0000_5398, 3'd4, "R11 bad");
    trial(32'h0000_0011, 3'd3, "R6 imm rel");
    trial(32'h0000_0091, 3'd2, "R6 ind");
    trial(32'h0000_0046, 3'd4, "R7 move long");
    trial(32'h0000_0046, 3'd3, "R2 move long short");
    trial(32'h0000_00A7, 3'd4, "R8 bitw");
    trial(32'h0000_0047, 3'd3, "R8 imm16");
    trial(32'h0000_0018, 3'd3, "R9 bit branch");
    trial(32'h0000_00E8, 3'd2, "R9 bit modify");
    trial(32'h0000_008F, 3'd2, "R10 word");
    trial(32'h0000_009E, 3'd3, "R10 long");
    trial(32'h0000_0000, 3'd0, "R2 empty");

    // R3 backpressure
    out_ready = 1'b0;
    trial(32'h0000_0057, 3'd4, "R3 first");
    @(negedge clk);
    in_bytes = 32'h0000_0001; in_count = 3'd4; in_valid = 1'b1;
    #1 chk(in_ready == 1'b0, "R3 in_ready", int'(in_ready), 0);
    repeat (3) begin
      @(negedge clk);
      chk(out_valid && out_len == 3'd3 && out_mode == 4'd5 && out_class == 7'h35, "R3 hold",
          int'(out_class), 32'h35);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_class == 7'h10 && out_len == 3'd3, "R3 release", int'(out_class), 32'h10);
    @(negedge clk);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] by; logic [2:0] cnt;
      by = $urandom;
      case ($urandom_range(0, 3))
        0: begin by[7:0] = 8'h40; if ($urandom_range(0, 1) == 1) by[13:8] = 6'd0; end
        1: begin by[7:0] = 8'h98; if ($urandom_range(0, 1) == 1) by[11:8] = 4'd0; end
        default: ;
      endcase
      cnt = 3'($urandom_range(0, 4));
      trial(by, cnt, "R4-R11 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule